// File: doc/BRIEF.md
# Overridable Interrupt Vector Table

This block answers every CPU access to the lowest sixteen word addresses of memory. That window holds eight vector slots of two 16-bit words each. Slot 0 is the reset vector. Slots 1 to 7 are interrupt vectors. Each vector is a bare 24-bit target address: the low word carries bits 15:0, and the low byte of the high word carries bits 23:16.

After reset, every slot returns its fixed default, which the boot ROM supplies on a flat input bus. Software can redirect an interrupt slot in two steps. It first writes the low word, which is only staged. It then writes the high word. If the combined 24-bit value is non-zero, the slot switches to an internal copy of that value. If the value is zero, the slot drops back to its ROM default. The reset slot ignores all writes.

The interrupt controller reads the current target of any slot through a separate lookup port that has no latency. A chip-select output tells the memory system when this block owns the access on the bus.

Top module: `ivt_overlay`

## Requirements
- R1: `sel_o` is high exactly when `req_i` is high and `addr_i` is below 16; accesses at or above 16 are left to the rest of the memory system.
- R2: After reset, every slot returns its ROM default (`rom_table_i[24n+23:24n]` for slot n) on both the bus and the lookup port.
- R3: A selected read at word address 2n returns bits 15:0 of slot n's current vector, and a read at 2n+1 returns bits 23:16 in its low byte. `rdata_o` is zero whenever `sel_o` is low.
- R4: A write to the low word (even address) of a slot only stages the data; the value returned by that slot does not change.
- R5: A write to the high word (odd address) of slot 1 to 7 whose combined value {wdata[7:0], staged low word} is non-zero makes that slot return the combined value from the next cycle on.
- R6: A high-word write whose combined 24-bit value is zero clears the override, and the slot returns its ROM default from the next cycle on.
- R7: Writes to addresses 0 and 1 (the reset slot) never change what slot 0 returns.
- R8: Bits 15:8 of a high-word write are discarded, and bits 15:8 of a high-word read are always zero.
- R9: `vec_addr_o` shows the current 24-bit vector of slot `vec_idx_i` in the same cycle, with no register in the path.
- R10: Writes to addresses at or above 16 change no slot.
- R11: The zero test covers all 24 bits: a zero low word combined with a non-zero high byte still installs an override.
- R12: Asserting `rst_ni` low clears every override at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access valid |
| we_i | input | 1 | Access is a write |
| addr_i | input | 24 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, zero when not selected |
| sel_o | output | 1 | Block claims the current access |
| rom_table_i | input | 192 | Boot ROM defaults, slot n in bits 24n+23:24n |
| vec_idx_i | input | 3 | Slot index for vector lookup |
| vec_addr_o | output | 24 | Current vector of the indexed slot |

## Verification
A hidden override flag or a staged low word that holds the wrong value cannot be seen until that slot is read or looked up. The bench therefore drives a random lookup index every cycle and compares both ports against a reference model on every clock. This exposes a corrupted slot within one cycle of the first access that touches it. Directed sequences cover the cases that random traffic hits rarely: a staged low word that is never completed, a reverting write of zero, a zero low word paired with a non-zero high byte, writes to the locked reset slot and to addresses past the window, and a reset pulse that arrives between clock edges.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;
  localparam int IVT_ADDR_W    = 24;
  localparam int IVT_DATA_W    = 16;
  localparam int IVT_VEC_W     = 24;
  localparam int IVT_NUM_SLOTS = 8;

  typedef enum logic {
    HALF_LO = 1'b0,
    HALF_HI = 1'b1
  } ivt_half_e;
endpackage

// File: rtl/ivt_decode.sv
`timescale 1ns/1ps
module ivt_decode
  import ivt_pkg::*;
#(
  parameter int ADDR_W = IVT_ADDR_W,
  parameter int SLOT_W = 3
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic              wr_o,
  output logic [SLOT_W-1:0] slot_o,
  output ivt_half_e         half_o
);
  localparam int WIN_W = SLOT_W + 1;

  always_comb begin
    hit_o  = req_i && (addr_i[ADDR_W-1:WIN_W] == '0);
    wr_o   = hit_o && we_i;
    slot_o = addr_i[WIN_W-1:1];
    half_o = addr_i[0] ? HALF_HI : HALF_LO;
  end
endmodule

// File: rtl/ivt_slot.sv
`timescale 1ns/1ps
module ivt_slot
  import ivt_pkg::*;
#(
  parameter int DATA_W = IVT_DATA_W,
  parameter int VEC_W  = IVT_VEC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [VEC_W-1:0]  rom_vec_i,
  output logic [VEC_W-1:0]  eff_vec_o
);
  localparam int HI_W = VEC_W - DATA_W;

  logic [DATA_W-1:0] stage_q;
  logic [VEC_W-1:0]  ovr_q;
  logic              ovr_en_q;
  logic [VEC_W-1:0]  cand;

  // high byte of this write joined with the staged low word
  assign cand = {wdata_i[HI_W-1:0], stage_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q  <= '0;
      ovr_q    <= '0;
      ovr_en_q <= 1'b0;
    end else begin
      if (wr_lo_i) stage_q <= wdata_i;
      if (wr_hi_i) begin
        if (cand == '0) begin
          ovr_en_q <= 1'b0;
        end else begin
          ovr_en_q <= 1'b1;
          ovr_q    <= cand;
        end
      end
    end
  end

  assign eff_vec_o = ovr_en_q ? ovr_q : rom_vec_i;
endmodule

// File: rtl/ivt_read_mux.sv
`timescale 1ns/1ps
module ivt_read_mux
  import ivt_pkg::*;
#(
  parameter int DATA_W    = IVT_DATA_W,
  parameter int VEC_W     = IVT_VEC_W,
  parameter int NUM_SLOTS = IVT_NUM_SLOTS,
  parameter int SLOT_W    = 3
) (
  input  logic [NUM_SLOTS-1:0][VEC_W-1:0] eff_tbl_i,
  input  logic                            hit_i,
  input  logic [SLOT_W-1:0]               slot_i,
  input  ivt_half_e                       half_i,
  input  logic [SLOT_W-1:0]               vec_idx_i,
  output logic [DATA_W-1:0]               rdata_o,
  output logic [VEC_W-1:0]                vec_addr_o
);
  localparam int HI_W  = VEC_W - DATA_W;
  localparam int PAD_W = DATA_W - HI_W;

  logic [VEC_W-1:0] bus_vec;

  always_comb begin
    bus_vec = eff_tbl_i[slot_i];
    if (!hit_i)                rdata_o = '0;
    else if (half_i == HALF_HI) rdata_o = {{PAD_W{1'b0}}, bus_vec[VEC_W-1:DATA_W]};
    else                       rdata_o = bus_vec[DATA_W-1:0];
    vec_addr_o = eff_tbl_i[vec_idx_i];
  end
endmodule

// File: rtl/ivt_overlay.sv
`timescale 1ns/1ps
module ivt_overlay
  import ivt_pkg::*;
#(
  parameter int ADDR_W    = IVT_ADDR_W,
  parameter int DATA_W    = IVT_DATA_W,
  parameter int VEC_W     = IVT_VEC_W,
  parameter int NUM_SLOTS = IVT_NUM_SLOTS
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       req_i,
  input  logic                       we_i,
  input  logic [ADDR_W-1:0]          addr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [DATA_W-1:0]          rdata_o,
  output logic                       sel_o,
  input  logic [NUM_SLOTS*VEC_W-1:0] rom_table_i,
  input  logic [$clog2(NUM_SLOTS)-1:0] vec_idx_i,
  output logic [VEC_W-1:0]           vec_addr_o
);
  localparam int SLOT_W = $clog2(NUM_SLOTS);

  logic              hit, wr;
  logic [SLOT_W-1:0] slot;
  ivt_half_e         half;

  logic [NUM_SLOTS-1:0][VEC_W-1:0] rom_tbl;
  logic [NUM_SLOTS-1:0][VEC_W-1:0] eff_tbl;
  logic [NUM_SLOTS*VEC_W-1:0]      eff_flat;

  assign rom_tbl  = rom_table_i;
  assign eff_flat = eff_tbl;
  assign sel_o    = hit;

  ivt_decode #(
    .ADDR_W(ADDR_W),
    .SLOT_W(SLOT_W)
  ) decode_i (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .hit_o (hit),
    .wr_o  (wr),
    .slot_o(slot),
    .half_o(half)
  );

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    if (g == 0) begin : g_locked
      // reset slot always reads the boot ROM
      assign eff_tbl[g] = rom_tbl[g];
    end else begin : g_over
      logic hit_slot;
      assign hit_slot = wr && (slot == SLOT_W'(g));
      ivt_slot #(
        .DATA_W(DATA_W),
        .VEC_W (VEC_W)
      ) slot_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_lo_i  (hit_slot && (half == HALF_LO)),
        .wr_hi_i  (hit_slot && (half == HALF_HI)),
        .wdata_i  (wdata_i),
        .rom_vec_i(rom_tbl[g]),
        .eff_vec_o(eff_tbl[g])
      );
    end
  end

  ivt_read_mux #(
    .DATA_W   (DATA_W),
    .VEC_W    (VEC_W),
    .NUM_SLOTS(NUM_SLOTS),
    .SLOT_W   (SLOT_W)
  ) mux_i (
    .eff_tbl_i (eff_tbl),
    .hit_i     (hit),
    .slot_i    (slot),
    .half_i    (half),
    .vec_idx_i (vec_idx_i),
    .rdata_o   (rdata_o),
    .vec_addr_o(vec_addr_o)
  );
endmodule

// File: rtl/ivt_overlay_chk.sv
`timescale 1ns/1ps
module ivt_overlay_chk #(
  parameter int DATA_W    = 16,
  parameter int VEC_W     = 24,
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3,
  parameter int HI_W      = 8
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       req_i,
  input logic                       we_i,
  input logic                       half_bit_i,
  input logic [SLOT_W-1:0]          slot_bits_i,
  input logic [HI_W-1:0]            wdata_hi_i,
  input logic [DATA_W-1:0]          rdata_o,
  input logic                       sel_o,
  input logic [VEC_W-1:0]           rom0_i,
  input logic [SLOT_W-1:0]          vec_idx_i,
  input logic [VEC_W-1:0]           vec_addr_o,
  input logic [NUM_SLOTS*VEC_W-1:0] eff_flat
);
  logic              wr_sel, wr_lo, wr_hi_nz;
  logic [SLOT_W-1:0] last_slot;
  logic [VEC_W-1:0]  eff_last, eff_idx, eff0;

  assign wr_sel   = req_i && we_i && sel_o;
  assign wr_lo    = wr_sel && !half_bit_i;
  assign wr_hi_nz = wr_sel && half_bit_i && (slot_bits_i != '0) && (wdata_hi_i != '0);
  assign eff_last = eff_flat[last_slot*VEC_W +: VEC_W];
  assign eff_idx  = eff_flat[vec_idx_i*VEC_W +: VEC_W];
  assign eff0     = eff_flat[VEC_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) last_slot <= '0;
    else         last_slot <= slot_bits_i;
  end

  a_r3_quiet_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_o |-> rdata_o == '0);

  a_r8_hi_byte_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_o && half_bit_i) |-> rdata_o[DATA_W-1:HI_W] == '0);

  a_r4_low_stages_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo |=> $stable(eff_flat));

  a_r10_outside_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !sel_o) |=> $stable(eff_flat));

  a_r5_override_taken: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_nz |=> eff_last[VEC_W-1:DATA_W] == $past(wdata_hi_i));

  a_r7_reset_slot_fixed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff0 == rom0_i);

  a_r9_lookup_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_addr_o == eff_idx);
endmodule

bind ivt_overlay ivt_overlay_chk #(
  .DATA_W   (DATA_W),
  .VEC_W    (VEC_W),
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_W   (SLOT_W),
  .HI_W     (VEC_W - DATA_W)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_i      (req_i),
  .we_i       (we_i),
  .half_bit_i (addr_i[0]),
  .slot_bits_i(addr_i[SLOT_W:1]),
  .wdata_hi_i (wdata_i[VEC_W-DATA_W-1:0]),
  .rdata_o    (rdata_o),
  .sel_o      (sel_o),
  .rom0_i     (rom_table_i[VEC_W-1:0]),
  .vec_idx_i  (vec_idx_i),
  .vec_addr_o (vec_addr_o),
  .eff_flat   (eff_flat)
);

// File: tb/ivt_overlay_tb_top.sv
`timescale 1ns/1ps
module ivt_overlay_tb_top;
  localparam int AW = 24, DW = 16, VW = 24, NS = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic          req = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic          sel;
  logic [2:0]    vidx = '0;
  logic [VW-1:0] vaddr;
  logic [NS*VW-1:0] rom;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [VW-1:0] m_rom [NS];
  logic [VW-1:0] m_val [NS];
  logic [DW-1:0] m_stage [NS];
  bit            m_flag [NS];

  ivt_overlay dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .req_i      (req),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i    (wdata),
    .rdata_o    (rdata),
    .sel_o      (sel),
    .rom_table_i(rom),
    .vec_idx_i  (vidx),
    .vec_addr_o (vaddr)
  );

  function automatic logic [VW-1:0] m_eff(int n);
    if (n != 0 && m_flag[n]) return m_val[n];
    return m_rom[n];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < NS; i++) begin
      m_flag[i] = 0; m_val[i] = '0; m_stage[i] = '0;
    end
  endtask

  // one bus cycle: drive after the edge, compare at the falling edge, then advance the model
  task automatic step(string tag, logic r, logic w, logic [AW-1:0] a, logic [DW-1:0] d);
    logic [VW-1:0] e, cv;
    logic [DW-1:0] exp_rd;
    bit in_win;
    int s;
    @(posedge clk); #1;
    req = r; we = w; addr = a; wdata = d; vidx = 3'($urandom_range(0, 7));
    @(negedge clk);
    in_win = r && (a < 16);
    s = int'(a[3:1]);
    chk("R1", "sel", 32'(sel), 32'(in_win));
    if (!in_win) exp_rd = '0;
    else begin
      e = m_eff(s);
      exp_rd = a[0] ? {8'h00, e[23:16]} : e[15:0];
    end
    chk(tag, "rdata", 32'(rdata), 32'(exp_rd));
    chk("R9", "vec_addr", 32'(vaddr), 32'(m_eff(int'(vidx))));
    if (in_win && w && s != 0) begin
      if (!a[0]) m_stage[s] = d;
      else begin
        cv = {d[7:0], m_stage[s]};
        if (cv == '0) m_flag[s] = 0;
        else begin m_flag[s] = 1; m_val[s] = cv; end
      end
    end
  endtask

  task automatic rd_slot(string tag, int s);
    step(tag, 1'b1, 1'b0, AW'(2 * s), '0);
    step(tag, 1'b1, 1'b0, AW'(2 * s + 1), '0);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_rom[i] = 24'h0F0000 + 24'(i) * 24'h012345 + 24'h000001;
      rom[i*VW +: VW] = m_rom[i];
    end
    model_reset();
    repeat (2) @(posedge clk);
    // R2: lookup during reset
    for (int i = 0; i < NS; i++) begin
      vidx = 3'(i); #1;
      chk("R2", "reset lookup", 32'(vaddr), 32'(m_rom[i]));
    end
    @(negedge clk);
    chk("R1", "sel idle", 32'(sel), 32'd0);
    chk("R3", "rdata idle", 32'(rdata), 32'd0);
    rst_ni = 1'b1;
    for (int i = 0; i < NS; i++) rd_slot("R2", i);

    // R4: staged low word alone changes nothing
    step("R4", 1, 1, 24'd6, 16'h1234);
    rd_slot("R4", 3);
    // R5 + R8: complete with high word, junk in upper byte
    step("R5", 1, 1, 24'd7, 16'hFF56);
    rd_slot("R5", 3);
    step("R8", 1, 0, 24'd7, '0);
    // R6: zero combined value reverts
    step("R6", 1, 1, 24'd6, 16'h0000);
    step("R6", 1, 1, 24'd7, 16'hAB00);
    rd_slot("R6", 3);
    // R11: zero low word, non-zero high byte still overrides
    step("R11", 1, 1, 24'd7, 16'h0001);
    rd_slot("R11", 3);
    step("R11", 1, 1, 24'd7, 16'h0000);
    rd_slot("R11", 3);
    // R7: reset slot locked
    step("R7", 1, 1, 24'd0, 16'hBEEF);
    step("R7", 1, 1, 24'd1, 16'h00CD);
    rd_slot("R7", 0);
    // R10: writes past the window
    step("R10", 1, 1, 24'd16, 16'h5555);
    step("R10", 1, 1, 24'd17, 16'h0077);
    step("R10", 1, 1, 24'h001003, 16'h0011);
    step("R10", 1, 0, 24'd17, '0);
    for (int i = 0; i < NS; i++) rd_slot("R10", i);

    // R3: mixed traffic against the model
    for (int k = 0; k < 600; k++) begin
      logic [DW-1:0] d;
      d = ($urandom_range(0, 3) == 0) ? 16'h0000 : 16'($urandom);
      step("R3", 1'($urandom_range(0, 7) != 0), 1'($urandom_range(0, 1)),
           AW'($urandom_range(0, 19)), d);
    end

    // R12: asynchronous reset between edges
    step("R12", 1, 1, 24'd4, 16'h4321);
    step("R12", 1, 1, 24'd5, 16'h0099);
    step("R12", 1, 1, 24'd14, 16'h0007);
    step("R12", 1, 1, 24'd15, 16'h0042);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
    #1 rst_ni = 1'b0;
    model_reset();
    for (int i = 0; i < NS; i++) begin
      vidx = 3'(i); #0.5;
      chk("R12", "async clear", 32'(vaddr), 32'(m_rom[i]));
    end
    @(negedge clk);
    rst_ni = 1'b1;
    for (int i = 0; i < NS; i++) rd_slot("R12", i);

    summary();
    $finish;
  end
endmodule